// File: doc/BRIEF.md
# Regulator Protection Supervisor

A clocked fault manager for a power controller with two output channels. Analog comparators and hysteresis sit outside the block; it receives their results as digital flags, one for each fault: input under-voltage, input over-voltage, over-current on each channel, output under-voltage on each channel, output over-voltage on channel 1, and over-temperature. It also receives the enable input, an internal-supply-reset flag, a temperature-recovered flag and one soft-start-active flag for each channel.

Some faults must persist before they count. Input over-voltage, input under-voltage and each channel's over-current each have their own mask timer. These timers count a microsecond tick that a prescaler derives from the clock. A fault that has qualified is held according to its own release rule: latched, released automatically when its flag clears, or hiccup. While any fault is held, the block asks the channels to shut down, reports a fault-active level to the power-good logic, and shows a code that names the first fault to trip.

Top module: `psv_top`

## Requirements
- R1: After reset, faultActive is 0 and faultCode is 0, and no fault is held.
- R2: Input over-voltage (vinOver) trips only after it has stayed high for VINOV_MASK ticks, which is 5 ms by default. The fault releases on the cycle after vinOver falls.
- R3: Over-current on either channel (oc1Flag, oc2Flag) trips only after it has stayed high for OC_MASK ticks. The fault is latched: it stays held after its flag drops.
- R4: Each mask timer returns to zero whenever its flag goes low before expiry. Repeated short pulses therefore never trip a fault.
- R5: A channel under-voltage flag trips a latched fault on the next clock with no mask. It is ignored while that channel's soft-start flag is high or while enable is low.
- R6: Channel-1 output over-voltage trips on the next clock with no mask. It stays held until vout1Ov is low and then releases by itself (hiccup).
- R7: Over-temperature trips on the next clock with no mask. It releases only when enable is high, tempRecovered is high and otFlag is low.
- R8: Input under-voltage trips after VINUV_MASK ticks (32 µs by default). It releases only when vinUnder is low and enable is high.
- R9: Latched faults (both over-currents and both channel under-voltages) are cleared by enable low. A high supplyReset clears every held fault and every mask timer, and blocks new trips in that cycle.
- R10: shutdownReq is high when any fault is held, when enable is low, or when supplyReset is high. faultActive is high exactly when a fault is held.
- R11: faultCode uses these values: 0 none, 1 over-temperature, 2 input over-voltage, 3 input under-voltage, 4 channel-1 over-current, 5 channel-2 over-current, 6 channel-1 under-voltage, 7 channel-2 under-voltage, 8 channel-1 output over-voltage. The code is captured when the first fault trips. If several faults trip at once, the lowest value wins. The code holds while any fault stays held and returns to 0 when none is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Device enable |
| supplyReset | input | 1 | Internal supply reset flag |
| vinUnder | input | 1 | Input under-voltage flag |
| vinOver | input | 1 | Input over-voltage flag |
| oc1Flag | input | 1 | Channel-1 over-current flag |
| oc2Flag | input | 1 | Channel-2 over-current flag |
| uv1Flag | input | 1 | Channel-1 output under-voltage flag |
| uv2Flag | input | 1 | Channel-2 output under-voltage flag |
| vout1Ov | input | 1 | Channel-1 output over-voltage flag |
| otFlag | input | 1 | Over-temperature flag |
| tempRecovered | input | 1 | Die temperature below the release point |
| ss1Active | input | 1 | Channel-1 soft-start in progress |
| ss2Active | input | 1 | Channel-2 soft-start in progress |
| shutdownReq | output | 1 | Request to turn all channels off |
| faultActive | output | 1 | A fault is held (to power-good logic) |
| faultCode | output | 4 | Code of the first fault that tripped |

## Verification
The bench sends over-voltage pulses that stop just short of the mask. A design that failed to clear its timer on a gap would add the pulses together and shut down falsely. It holds a channel under-voltage during soft-start, where a design that misses the soft-start gate would latch a fault at power-up. It sends over-temperature with enable low and tempRecovered high, where a design that releases too early would restart while disabled. It also sends simultaneous faults and then adds a later fault while one is held. A wrong encoder would report the wrong code, and a code that is not frozen would change while a fault is held.

// File: rtl/psv_pkg.sv
package psv_pkg;
  localparam int NUM_FAULTS = 8;
  localparam int NUM_TIMED  = 4;

  // timed fault indices inside the mask datapath
  localparam int TI_VINOV = 0;
  localparam int TI_VINUV = 1;
  localparam int TI_OC1   = 2;
  localparam int TI_OC2   = 3;

  // held-fault bit positions; code = position + 1, lower position wins
  localparam int FB_OTEMP  = 0;
  localparam int FB_VINOV  = 1;
  localparam int FB_VINUV  = 2;
  localparam int FB_OC1    = 3;
  localparam int FB_OC2    = 4;
  localparam int FB_UV1    = 5;
  localparam int FB_UV2    = 6;
  localparam int FB_VOUTOV = 7;

  localparam logic [NUM_FAULTS-1:0] LATCHED_SET = 8'b0111_1000;

  typedef struct packed {
    logic clrTimers;
  } ctrlStrobe_t;
endpackage

// File: rtl/psv_mask_timers.sv
module psv_mask_timers
  import psv_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int VINOV_MASK = 5000,
  parameter int VINUV_MASK = 32,
  parameter int OC_MASK    = 4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_TIMED-1:0] flags,
  output logic [NUM_TIMED-1:0] expired
);
  localparam int MAXM = (VINOV_MASK > OC_MASK) ?
                        ((VINOV_MASK > VINUV_MASK) ? VINOV_MASK : VINUV_MASK) :
                        ((OC_MASK > VINUV_MASK) ? OC_MASK : VINUV_MASK);
  localparam int MW = $clog2(MAXM + 1);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] prescCnt;
  logic          tick;

  assign tick = (prescCnt == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prescCnt <= '0;
    else if (tick) prescCnt <= '0;
    else           prescCnt <= prescCnt + PW'(1);
  end

  for (genvar i = 0; i < NUM_TIMED; i++) begin : g_mask
    localparam int LIM = (i == TI_VINOV) ? VINOV_MASK :
                         (i == TI_VINUV) ? VINUV_MASK : OC_MASK;
    logic [MW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt <= '0;
      else if (strobe.clrTimers || !flags[i])   cnt <= '0;
      else if (tick && (cnt != MW'(LIM)))       cnt <= cnt + MW'(1);
    end

    assign expired[i] = (cnt == MW'(LIM));
  end
endmodule

// File: rtl/psv_fault_ctrl.sv
module psv_fault_ctrl
  import psv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  supplyReset,
  input  logic                  vinUnder,
  input  logic                  vinOver,
  input  logic                  oc1Flag,
  input  logic                  oc2Flag,
  input  logic                  uv1Flag,
  input  logic                  uv2Flag,
  input  logic                  vout1Ov,
  input  logic                  otFlag,
  input  logic                  tempRecovered,
  input  logic                  ss1Active,
  input  logic                  ss2Active,
  input  logic [NUM_TIMED-1:0]  expired,
  output ctrlStrobe_t           strobe,
  output logic [NUM_FAULTS-1:0] held,
  output logic [3:0]            code
);
  logic [NUM_FAULTS-1:0] trip, keep, heldNext;
  logic [3:0]            firstCode;

  assign strobe.clrTimers = supplyReset;

  always_comb begin
    trip = '0;
    trip[FB_OTEMP]  = otFlag;
    trip[FB_VINOV]  = vinOver  & expired[TI_VINOV];
    trip[FB_VINUV]  = vinUnder & expired[TI_VINUV];
    trip[FB_OC1]    = oc1Flag  & expired[TI_OC1];
    trip[FB_OC2]    = oc2Flag  & expired[TI_OC2];
    trip[FB_UV1]    = uv1Flag  & ~ss1Active;
    trip[FB_UV2]    = uv2Flag  & ~ss2Active;
    trip[FB_VOUTOV] = vout1Ov;

    keep = '0;
    keep[FB_OTEMP]  = ~(enable & tempRecovered & ~otFlag);
    keep[FB_VINOV]  = vinOver;
    keep[FB_VINUV]  = vinUnder | ~enable;
    keep[FB_VOUTOV] = vout1Ov;
  end

  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_rule
    if (LATCHED_SET[i]) begin : g_latched
      assign heldNext[i] = ~supplyReset & enable & (trip[i] | held[i]);
    end else begin : g_auto
      assign heldNext[i] = ~supplyReset & (trip[i] | (held[i] & keep[i]));
    end
  end

  always_comb begin
    firstCode = 4'd0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (heldNext[i]) firstCode = 4'(i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      code <= 4'd0;
    end else begin
      held <= heldNext;
      if (heldNext == '0)  code <= 4'd0;
      else if (held == '0) code <= firstCode;
    end
  end
endmodule

// File: rtl/psv_top.sv
module psv_top
  import psv_pkg::*;
#(
  parameter int TICK_DIV   = 50,
  parameter int VINOV_MASK = 5000,
  parameter int VINUV_MASK = 32,
  parameter int OC_MASK    = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       supplyReset,
  input  logic       vinUnder,
  input  logic       vinOver,
  input  logic       oc1Flag,
  input  logic       oc2Flag,
  input  logic       uv1Flag,
  input  logic       uv2Flag,
  input  logic       vout1Ov,
  input  logic       otFlag,
  input  logic       tempRecovered,
  input  logic       ss1Active,
  input  logic       ss2Active,
  output logic       shutdownReq,
  output logic       faultActive,
  output logic [3:0] faultCode
);
  ctrlStrobe_t           strobe;
  logic [NUM_TIMED-1:0]  expired, timedFlags;
  logic [NUM_FAULTS-1:0] held;

  always_comb begin
    timedFlags = '0;
    timedFlags[TI_VINOV] = vinOver;
    timedFlags[TI_VINUV] = vinUnder;
    timedFlags[TI_OC1]   = oc1Flag;
    timedFlags[TI_OC2]   = oc2Flag;
  end

  psv_mask_timers #(
    .TICK_DIV(TICK_DIV), .VINOV_MASK(VINOV_MASK),
    .VINUV_MASK(VINUV_MASK), .OC_MASK(OC_MASK)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .flags(timedFlags), .expired(expired)
  );

  psv_fault_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supplyReset(supplyReset),
    .vinUnder(vinUnder), .vinOver(vinOver), .oc1Flag(oc1Flag), .oc2Flag(oc2Flag),
    .uv1Flag(uv1Flag), .uv2Flag(uv2Flag), .vout1Ov(vout1Ov), .otFlag(otFlag),
    .tempRecovered(tempRecovered), .ss1Active(ss1Active), .ss2Active(ss2Active),
    .expired(expired), .strobe(strobe), .held(held), .code(faultCode)
  );

  assign faultActive = |held;
  assign shutdownReq = faultActive | ~enable | supplyReset;
endmodule

// File: rtl/psv_checker.sv
module psv_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       supplyReset,
  input logic       uv1Flag,
  input logic       ss1Active,
  input logic       vout1Ov,
  input logic       otFlag,
  input logic       faultActive,
  input logic [3:0] faultCode
);
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !faultActive |-> faultCode == 4'd0);                                   // R11
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (faultActive && $past(faultActive)) |-> $stable(faultCode));           // R11
  AST_VOUT_OV_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (vout1Ov && !supplyReset) |=> faultActive);                            // R6
  AST_UV1_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (uv1Flag && !ss1Active && enable && !supplyReset) |=> faultActive);    // R5
  AST_OT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (otFlag && !supplyReset) |=> faultActive);                             // R7
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    supplyReset |=> !faultActive);                                         // R9
endmodule

bind psv_top psv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .supplyReset(supplyReset),
  .uv1Flag(uv1Flag), .ss1Active(ss1Active), .vout1Ov(vout1Ov), .otFlag(otFlag),
  .faultActive(faultActive), .faultCode(faultCode)
);

// File: tb/sim_psv_top.sv
`timescale 1ns/1ps
module sim_psv_top;
  localparam int DIV = 2, OVM = 10, UVM = 4, OCM = 8;

  logic clk = 0, rst_n = 0;
  logic enable = 0, supplyReset = 0, vinUnder = 0, vinOver = 0;
  logic oc1Flag = 0, oc2Flag = 0, uv1Flag = 0, uv2Flag = 0, vout1Ov = 0;
  logic otFlag = 0, tempRecovered = 1, ss1Active = 0, ss2Active = 0;
  logic shutdownReq, faultActive;
  logic [3:0] faultCode;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  psv_top #(.TICK_DIV(DIV), .VINOV_MASK(OVM), .VINUV_MASK(UVM), .OC_MASK(OCM)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supplyReset(supplyReset),
    .vinUnder(vinUnder), .vinOver(vinOver), .oc1Flag(oc1Flag), .oc2Flag(oc2Flag),
    .uv1Flag(uv1Flag), .uv2Flag(uv2Flag), .vout1Ov(vout1Ov), .otFlag(otFlag),
    .tempRecovered(tempRecovered), .ss1Active(ss1Active), .ss2Active(ss2Active),
    .shutdownReq(shutdownReq), .faultActive(faultActive), .faultCode(faultCode)
  );

  // behavioural reference model
  int mPresc, mCode;
  int mCnt[4];
  int mLim[4] = '{OVM, UVM, OCM, OCM};
  bit mHeld[8];

  always @(posedge clk) begin
    bit tk, anyOld, anyNew;
    bit ex[4], fl[4], tr[8], nx[8];
    if (!rst_n) begin
      mPresc = 0; mCode = 0;
      foreach (mCnt[i]) mCnt[i] = 0;
      foreach (mHeld[i]) mHeld[i] = 0;
    end else begin
      tk = (mPresc == DIV - 1);
      mPresc = tk ? 0 : mPresc + 1;
      fl = '{vinOver, vinUnder, oc1Flag, oc2Flag};
      foreach (ex[i]) ex[i] = (mCnt[i] == mLim[i]);
      tr = '{otFlag, vinOver && ex[0], vinUnder && ex[1], oc1Flag && ex[2],
             oc2Flag && ex[3], uv1Flag && !ss1Active, uv2Flag && !ss2Active, vout1Ov};
      nx[0] = tr[0] || (mHeld[0] && !(enable && tempRecovered && !otFlag));
      nx[1] = tr[1] || (mHeld[1] && vinOver);
      nx[2] = tr[2] || (mHeld[2] && (vinUnder || !enable));
      for (int i = 3; i <= 6; i++) nx[i] = enable && (tr[i] || mHeld[i]);
      nx[7] = tr[7] || (mHeld[7] && vout1Ov);
      if (supplyReset) foreach (nx[i]) nx[i] = 0;
      anyOld = 0; anyNew = 0;
      foreach (nx[i]) begin anyOld |= mHeld[i]; anyNew |= nx[i]; end
      if (!anyNew) mCode = 0;
      else if (!anyOld) begin
        mCode = 0;
        for (int i = 7; i >= 0; i--) if (nx[i]) mCode = i + 1;
      end
      mHeld = nx;
      foreach (mCnt[i]) begin
        if (supplyReset || !fl[i]) mCnt[i] = 0;
        else if (tk && mCnt[i] < mLim[i]) mCnt[i]++;
      end
    end
  end

  function automatic bit modelActive();
    foreach (mHeld[i]) if (mHeld[i]) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    bit ma;
    ma = modelActive();
    chk(faultActive === ma, "R10 faultActive", faultActive, ma);
    chk(shutdownReq === (ma || !enable || supplyReset), "R10 shutdownReq",
        shutdownReq, ma || !enable || supplyReset);
    chk(faultCode === 4'(mCode), "R11 faultCode", faultCode, mCode);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic waitFault(input int limit);
    for (int k = 0; k < limit && !faultActive; k++) step(1);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk(faultActive == 0 && faultCode == 0, "R1 reset state", faultCode, 0);
    chk(shutdownReq == 1, "R10 disabled shutdown", shutdownReq, 1);
    enable = 1; step(1);
    chk(shutdownReq == 0, "R10 enabled idle", shutdownReq, 0);

    // R4: pulses just short of the mask, separated by gaps
    for (int p = 0; p < 3; p++) begin
      vinOver = 1; step((OVM - 2) * DIV); vinOver = 0; step(2);
    end
    chk(faultActive == 0, "R4 short pulses ignored", faultActive, 0);

    // R2: sustained input over-voltage
    vinOver = 1; step((OVM - 1) * DIV);
    chk(faultActive == 0, "R2 not before mask", faultActive, 0);
    waitFault(4 * DIV);
    chk(faultActive == 1 && faultCode == 2, "R2 trip code", faultCode, 2);
    vinOver = 0; step(1);
    chk(faultActive == 0 && faultCode == 0, "R2 auto release", faultCode, 0);

    // R3: channel-2 over-current, latched
    oc2Flag = 1; step((OCM - 1) * DIV);
    chk(faultActive == 0, "R3 not before mask", faultActive, 0);
    waitFault(4 * DIV);
    chk(faultCode == 5, "R3 trip code", faultCode, 5);
    oc2Flag = 0; step(10);
    chk(faultActive == 1, "R3 latched after flag drop", faultActive, 1);
    enable = 0; step(1);
    chk(faultActive == 0, "R9 enable low clears latch", faultActive, 0);
    enable = 1; step(1);

    // R5: under-voltage gated by soft-start
    ss1Active = 1; uv1Flag = 1; step(5);
    chk(faultActive == 0, "R5 ignored in soft-start", faultActive, 0);
    ss1Active = 0; step(1);
    chk(faultCode == 6, "R5 trip code", faultCode, 6);
    uv1Flag = 0; step(3);
    chk(faultActive == 1, "R5 latched", faultActive, 1);
    supplyReset = 1; step(1); supplyReset = 0;
    chk(faultActive == 0, "R9 supply reset clears", faultActive, 0);
    step(1);

    // R6: hiccup output over-voltage
    vout1Ov = 1; step(3);
    chk(faultCode == 8, "R6 trip code", faultCode, 8);
    vout1Ov = 0; step(1);
    chk(faultActive == 0, "R6 hiccup release", faultActive, 0);

    // R7: over-temperature release rule
    tempRecovered = 0; otFlag = 1; step(1);
    chk(faultCode == 1, "R7 trip code", faultCode, 1);
    otFlag = 0; step(3);
    chk(faultActive == 1, "R7 held until recovered", faultActive, 1);
    enable = 0; tempRecovered = 1; step(3);
    chk(faultActive == 1, "R7 held while disabled", faultActive, 1);
    enable = 1; step(1);
    chk(faultActive == 0, "R7 release", faultActive, 0);

    // R8: input under-voltage
    vinUnder = 1; step((UVM - 1) * DIV);
    chk(faultActive == 0, "R8 not before mask", faultActive, 0);
    waitFault(4 * DIV);
    chk(faultCode == 3, "R8 trip code", faultCode, 3);
    enable = 0; vinUnder = 0; step(3);
    chk(faultActive == 1, "R8 needs enable", faultActive, 1);
    enable = 1; step(1);
    chk(faultActive == 0, "R8 release", faultActive, 0);

    // R11: priority among simultaneous trips, then frozen code
    uv2Flag = 1; vout1Ov = 1; step(1);
    chk(faultCode == 7, "R11 priority", faultCode, 7);
    tempRecovered = 0; otFlag = 1; step(2);
    chk(faultCode == 7, "R11 code frozen", faultCode, 7);
    uv2Flag = 0; vout1Ov = 0; otFlag = 0; enable = 0; step(1);
    chk(faultActive == 1 && faultCode == 7, "R11 code held with OT", faultCode, 7);
    enable = 1; tempRecovered = 1; step(1);
    chk(faultActive == 0 && faultCode == 0, "R11 code cleared", faultCode, 0);

    step(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule